// File: doc/BRIEF.md
# Programmable Chip Select and Wait Generator

This block sits beside a bus unit and turns each bus cycle into at most one active-low chip select, plus the end-of-cycle strobe for that access. When the bus unit starts a cycle it presents the address and whether the cycle is memory or I/O. The block compares the address against the programmed regions and latches the matching select. It then holds that select low until its wait-state counter runs out and, if the region honours it, the external ready input is high. Memory space is split into an upper block anchored at the top of the 1 MB space, a lower block anchored at address 0, and a mid-range window divided into four equal quarters. I/O space carries seven adjacent 128-byte peripheral windows above a programmable base.

Five 16-bit configuration registers are written through a simple write port. The upper block comes out of reset already usable: a 1 KB block with three wait states plus external ready. Every other region stays silent until software has written its registers. During reset every select output is high.

The sequencer has three states. `ST_IDLE` waits for a cycle start; the transition *launch* moves it to `ST_COUNT`, loading the wait count and latching the decoded select. In `ST_COUNT` the transition *tick* decrements the count. When the count is zero, *finish* returns to `ST_IDLE` if ready is ignored or present; otherwise *stall* moves to `ST_AWAIT_RDY`. From `ST_AWAIT_RDY`, *release* returns to `ST_IDLE` once external ready is high.

Top module: `chipsel_top`

## Requirements
- R1: While reset is held low, all thirteen select outputs are high and `cyc_done` is low.
- R2: After reset the upper register holds 16'hFFFB. A memory access at 20'hFFC00..20'hFFFFF therefore drives `upper_cs_n` low with 3 wait states plus external ready, and 20'hFFBFF selects nothing.
- R3: The lower select stays inactive until register 1 is written. The mid-range selects stay inactive until registers 2 and 3 are both written. The peripheral selects stay inactive until registers 3 and 4 are both written.
- R4: Register 0 (upper) bits [13:6] give F. The block matches memory addresses with addr[19:10] >= {2'b11, F}, which gives sizes of 1 KB to 256 KB ending at 20'hFFFFF.
- R5: Register 1 (lower) bits [13:6] give F. The block matches memory addresses with addr[19:10] <= {2'b00, F}, which gives sizes of 1 KB to 256 KB starting at 0.
- R6: Register 2 bits [15:9] set mid-range base bits [19:13]. Register 3 bits [14:12] give a size code n, with a size of 8 KB << n, where a code of 7 acts as 6 (512 KB). Quarter i of the window drives `mid_cs_n[i]`, in ascending address order.
- R7: Register 4 bits [15:10] set the peripheral base bits [15:10]. An I/O access with offset o = addr[15:0] - base below 896 drives `per_cs_n[o/128]`. I/O cycles never drive memory selects, and memory cycles never drive peripheral selects.
- R8: When regions overlap, the priority is upper over lower over mid-range. At most one select is low at any time.
- R9: In each region's ready field, bits [1:0] give the wait count W and bit 2 set means external ready is ignored. The mid-range field is in register 3 and the peripheral field is in register 4. The select goes low in the cycle after the start is sampled. `cyc_done` rises in cycle W+1 when ready is ignored, and the select returns high after that cycle.
- R10: When external ready is honoured, the access lasts max(W+1, r) cycles, where r is the first cycle, counted from the start cycle as 0, in which `ext_rdy` is high.
- R11: A memory or I/O access that matches no enabled region drives no select and behaves as W=0 with external ready honoured.
- R12: A `cyc_start` that arrives while an access is in progress is ignored, and the latched select does not change until `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register index 0..4 (5..7 ignored) |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_start | input | 1 | Bus cycle start, one clock |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 20 | Cycle address (I/O uses bits [15:0]) |
| ext_rdy | input | 1 | Synchronized external ready |
| cyc_done | output | 1 | High in the last clock of the access |
| upper_cs_n | output | 1 | Upper memory select |
| lower_cs_n | output | 1 | Lower memory select |
| mid_cs_n | output | 4 | Mid-range memory selects |
| per_cs_n | output | 7 | Peripheral selects |

## Verification
The assertions check on every cycle the properties that hold in every access: at most one select is low, all selects are high when no access is in flight, memory and I/O selects stay apart, the latched select holds still until `cyc_done`, and the gating of the lower and peripheral selects by register writes. The exact region boundaries, the priority between overlapping regions, the size-code clamp and the access length under different wait counts and ready timings depend on programmed values. Only the bench scenarios show these, by comparing each access against a predicted select and length.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;
    localparam int ADDR_W   = 20;
    localparam int IO_W     = 16;
    localparam int REG_W    = 16;
    localparam int N_MID    = 4;
    localparam int N_PER    = 7;
    localparam int SEL_W    = 2 + N_MID + N_PER;
    localparam int WAIT_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COUNT     = 2'd1,
        ST_AWAIT_RDY = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              no_ext;
        logic [WAIT_W-1:0] waits;
    } rdy_cfg_t;

    typedef struct packed {
        logic [REG_W-1:0] upper;
        logic [REG_W-1:0] lower;
        logic [REG_W-1:0] mid_base;
        logic [REG_W-1:0] mid_size;
        logic [REG_W-1:0] per_base;
        logic             lower_ok;
        logic             mid_ok;
        logic             per_ok;
    } cs_cfg_t;
endpackage

// File: rtl/chipsel_regs.sv
module chipsel_regs
    import chipsel_pkg::*;
#(
    parameter logic [REG_W-1:0] UPPER_RST = 16'hFFFB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output cs_cfg_t          cfg
);
    logic [REG_W-1:0] r_up, r_lo, r_mb, r_ms, r_pb;
    logic             w_lo, w_mb, w_ms, w_pb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_up <= UPPER_RST;
            r_lo <= '0;
            r_mb <= '0;
            r_ms <= '0;
            r_pb <= '0;
            w_lo <= 1'b0;
            w_mb <= 1'b0;
            w_ms <= 1'b0;
            w_pb <= 1'b0;
        end else if (we) begin
            unique case (sel)
                3'd0: r_up <= wdata;
                3'd1: begin r_lo <= wdata; w_lo <= 1'b1; end
                3'd2: begin r_mb <= wdata; w_mb <= 1'b1; end
                3'd3: begin r_ms <= wdata; w_ms <= 1'b1; end
                3'd4: begin r_pb <= wdata; w_pb <= 1'b1; end
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.upper    = r_up;
        cfg.lower    = r_lo;
        cfg.mid_base = r_mb;
        cfg.mid_size = r_ms;
        cfg.per_base = r_pb;
        cfg.lower_ok = w_lo;
        cfg.mid_ok   = w_mb & w_ms;
        cfg.per_ok   = w_pb & w_ms;
    end
endmodule

// File: rtl/chipsel_decode.sv
module chipsel_decode
    import chipsel_pkg::*;
(
    input  cs_cfg_t           cfg,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  hit,
    output rdy_cfg_t          rdy
);
    localparam int PER_SPAN = N_PER * 128;
    localparam int MID_LSB  = 2;
    localparam int PER_LSB  = 2 + N_MID;

    logic [9:0]        blk;
    logic              up_hit, lo_hit, mid_hit, per_hit;
    logic [ADDR_W-1:0] moff;
    logic [2:0]        szc;
    logic [1:0]        midx;
    logic [IO_W-1:0]   poff;
    logic [2:0]        pidx;
    logic [N_MID-1:0]  mid_vec;
    logic [N_PER-1:0]  per_vec;

    assign blk    = addr[ADDR_W-1:10];
    assign up_hit = !is_io && (blk >= {2'b11, cfg.upper[13:6]});
    assign lo_hit = !is_io && cfg.lower_ok && (blk <= {2'b00, cfg.lower[13:6]});

    assign szc    = (cfg.mid_size[14:12] == 3'd7) ? 3'd6 : cfg.mid_size[14:12];
    assign moff   = addr - {cfg.mid_base[15:9], 13'b0};
    always_comb begin
        logic [ADDR_W-1:0] top_part;
        logic [ADDR_W-1:0] q_part;
        top_part = moff >> (13 + int'(szc));
        q_part   = moff >> (11 + int'(szc));
        mid_hit  = !is_io && cfg.mid_ok && (top_part == '0);
        midx     = q_part[1:0];
    end

    assign poff    = addr[IO_W-1:0] - {cfg.per_base[15:10], 10'b0};
    assign per_hit = is_io && cfg.per_ok && (int'(poff) < PER_SPAN);
    assign pidx    = poff[9:7];

    genvar gi;
    generate
        for (gi = 0; gi < N_MID; gi++) begin : g_mid
            assign mid_vec[gi] = mid_hit && !up_hit && !lo_hit && (midx == 2'(gi));
        end
        for (gi = 0; gi < N_PER; gi++) begin : g_per
            assign per_vec[gi] = per_hit && (pidx == 3'(gi));
        end
    endgenerate

    always_comb begin
        hit = '0;
        hit[0] = up_hit;
        hit[1] = lo_hit && !up_hit;
        hit[PER_LSB-1:MID_LSB] = mid_vec;
        hit[SEL_W-1:PER_LSB]   = per_vec;
        rdy = '{no_ext: 1'b0, waits: '0};
        if (up_hit)        rdy = rdy_cfg_t'(cfg.upper[2:0]);
        else if (lo_hit)   rdy = rdy_cfg_t'(cfg.lower[2:0]);
        else if (mid_hit)  rdy = rdy_cfg_t'(cfg.mid_size[2:0]);
        else if (per_hit)  rdy = rdy_cfg_t'(cfg.per_base[2:0]);
    end

    logic unused_bits;
    assign unused_bits = ^{cfg.upper[15:14], cfg.upper[5:3], cfg.lower[15:14],
                           cfg.lower[5:3], cfg.mid_base[8:0], cfg.mid_size[15],
                           cfg.mid_size[11:3], cfg.per_base[9:3], moff[1:0],
                           poff[6:0]};
endmodule

// File: rtl/chipsel_seq.sv
module chipsel_seq
    import chipsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] hit,
    input  rdy_cfg_t         rdy,
    input  logic             ext_rdy,
    output logic [SEL_W-1:0] sel_n,
    output logic             done
);
    seq_state_t        state, nstate;
    logic [WAIT_W-1:0] cnt;
    logic [SEL_W-1:0]  sel_q;
    logic              no_ext_q;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:      if (start) nstate = ST_COUNT;
            ST_COUNT:     if (cnt == '0) nstate = (no_ext_q || ext_rdy) ? ST_IDLE : ST_AWAIT_RDY;
            ST_AWAIT_RDY: if (ext_rdy) nstate = ST_IDLE;
            default:      nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sel_q    <= '0;
            no_ext_q <= 1'b0;
        end else begin
            state <= nstate;
            if (state == ST_IDLE && start) begin
                cnt      <= rdy.waits;
                sel_q    <= hit;
                no_ext_q <= rdy.no_ext;
            end else if (state == ST_COUNT && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state != ST_IDLE && nstate == ST_IDLE) sel_q <= '0;
        end
    end

    always_comb begin
        sel_n = ~sel_q;
        unique case (state)
            ST_IDLE:      done = 1'b0;
            ST_COUNT:     done = (cnt == '0) && (no_ext_q || ext_rdy);
            ST_AWAIT_RDY: done = ext_rdy;
            default:      done = 1'b0;
        endcase
    end
endmodule

// File: rtl/chipsel_top.sv
module chipsel_top
    import chipsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              cyc_start,
    input  logic              cyc_is_io,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              ext_rdy,
    output logic              cyc_done,
    output logic              upper_cs_n,
    output logic              lower_cs_n,
    output logic [N_MID-1:0]  mid_cs_n,
    output logic [N_PER-1:0]  per_cs_n
);
    cs_cfg_t          cfg;
    logic [SEL_W-1:0] hit;
    rdy_cfg_t         rdy;
    logic [SEL_W-1:0] sel_n;

    chipsel_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    chipsel_decode u_dec (
        .cfg(cfg), .is_io(cyc_is_io), .addr(cyc_addr), .hit(hit), .rdy(rdy)
    );

    chipsel_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .hit(hit), .rdy(rdy),
        .ext_rdy(ext_rdy), .sel_n(sel_n), .done(cyc_done)
    );

    assign upper_cs_n = sel_n[0];
    assign lower_cs_n = sel_n[1];
    assign mid_cs_n   = sel_n[2+N_MID-1:2];
    assign per_cs_n   = sel_n[SEL_W-1:2+N_MID];
endmodule

// File: rtl/chipsel_checker.sv
module chipsel_checker
    import chipsel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic             cyc_start,
    input logic             cyc_is_io,
    input logic             cyc_done,
    input logic             upper_cs_n,
    input logic             lower_cs_n,
    input logic [N_MID-1:0] mid_cs_n,
    input logic [N_PER-1:0] per_cs_n
);
    logic busy_q, seen_lo, seen_ms, seen_pb;
    logic [SEL_W-1:0] act;
    assign act = ~{per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0; seen_lo <= 1'b0; seen_ms <= 1'b0; seen_pb <= 1'b0;
        end else begin
            if (!busy_q && cyc_start) busy_q <= 1'b1;
            else if (cyc_done)        busy_q <= 1'b0;
            if (cfg_we && cfg_sel == 3'd1) seen_lo <= 1'b1;
            if (cfg_we && cfg_sel == 3'd3) seen_ms <= 1'b1;
            if (cfg_we && cfg_sel == 3'd4) seen_pb <= 1'b1;
        end
    end

    p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act));
    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> act == '0);
    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) cyc_done |-> busy_q);
    p_hold_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !cyc_done) |=> $stable(act));
    p_io_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy_q && cyc_is_io) |=> (act[2+N_MID-1:0] == '0));
    p_mem_no_per_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy_q && !cyc_is_io) |=> (per_cs_n == '1));
    p_per_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(seen_ms && seen_pb) |-> (per_cs_n == '1));
    p_lower_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_lo |-> lower_cs_n);
endmodule

bind chipsel_top chipsel_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cyc_start(cyc_start), .cyc_is_io(cyc_is_io), .cyc_done(cyc_done),
    .upper_cs_n(upper_cs_n), .lower_cs_n(lower_cs_n),
    .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n)
);

// File: tb/sim_chipsel_top.sv
`timescale 1ns/1ps
module sim_chipsel_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic        cyc_is_io = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        cyc_done, upper_cs_n, lower_cs_n;
    logic [3:0]  mid_cs_n;
    logic [6:0]  per_cs_n;

    always #10 clk = ~clk;

    chipsel_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cyc_is_io(cyc_is_io),
        .cyc_addr(cyc_addr), .ext_rdy(ext_rdy), .cyc_done(cyc_done),
        .upper_cs_n(upper_cs_n), .lower_cs_n(lower_cs_n),
        .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n)
    );

    typedef struct { logic [12:0] sel; int len; string tag; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    bit mon_busy = 0;
    bit finished = 0;
    int mon_len = 0;
    logic [12:0] mon_sel = '0;

    localparam logic [12:0] NONE = 13'h0;
    localparam logic [12:0] UP   = 13'h1;
    localparam logic [12:0] LO   = 13'h2;
    function automatic logic [12:0] MID(input int i); return 13'(1 << (2 + i)); endfunction
    function automatic logic [12:0] PER(input int i); return 13'(1 << (6 + i)); endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed access
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mon_busy) begin
                if (cyc_start) begin mon_busy = 1; mon_len = 0; end
            end else begin
                mon_len++;
                if (mon_len == 1) mon_sel = ~{per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n};
                else chk(mon_sel == ~{per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n},
                         "R12 select held", int'(~{per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n}),
                         int'(mon_sel));
                if (cyc_done) begin
                    exp_t e;
                    mon_busy = 0;
                    if (q.size() == 0) chk(0, "scoreboard empty", mon_len, 0);
                    else begin
                        e = q.pop_front();
                        chk(mon_sel == e.sel, {e.tag, " select"}, int'(mon_sel), int'(e.sel));
                        chk(mon_len == e.len, {e.tag, " length"}, mon_len, e.len);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(posedge clk); #1; cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1; cfg_we = 0;
    endtask

    task automatic acc(input logic io, input logic [19:0] a, input int r,
                       input logic [12:0] es, input int el, input string tag,
                       input bit restart = 0);
        q.push_back('{sel: es, len: el, tag: tag});
        @(posedge clk); #1;
        cyc_start = 1; cyc_is_io = io; cyc_addr = a; ext_rdy = (r == 0);
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); #1;
            cyc_start = restart && (k == 1);
            if (restart && k == 1) begin cyc_is_io = 0; cyc_addr = 20'h00000; end
            if (k == r) ext_rdy = 1;
            if (!mon_busy) break;
        end
        cyc_start = 0; ext_rdy = 1;
        while (mon_busy) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n} == 13'h1FFF, "R1 selects high",
            int'({per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n}), 'h1FFF);
        chk(cyc_done == 0, "R1 done low", int'(cyc_done), 0);
        @(posedge clk); #1; rst_n = 1;

        // R2: upper reset value, 1K, 3 waits + ready
        acc(0, 20'hFFC00, 0, UP, 4, "R2 upper base");
        acc(0, 20'hFFFFF, 6, UP, 6, "R2 upper ready late R10");
        acc(0, 20'hFFBFF, 0, NONE, 1, "R2 below upper R11");
        acc(0, 20'hFFBFF, 2, NONE, 2, "R11 miss waits for ready");
        // R3: nothing else before writes
        acc(0, 20'h00000, 0, NONE, 1, "R3 lower unwritten");
        acc(1, 20'h00400, 0, NONE, 1, "R3 per unwritten");

        // R5: lower 4K, ignore ready, 1 wait
        wr(3'd1, 16'h00C5);
        acc(0, 20'h00FFF, 5, LO, 2, "R5 lower top R9");
        acc(0, 20'h01000, 0, NONE, 1, "R5 above lower");

        // R3: per base alone does not enable
        wr(3'd4, 16'h0402);
        acc(1, 20'h00400, 0, NONE, 1, "R3 per needs mid size");
        wr(3'd3, 16'h1004);
        // R7 windows, 2 waits with ready
        acc(1, 20'h00400, 0, PER(0), 3, "R7 per0 R10");
        acc(1, 20'h00480, 0, PER(1), 3, "R7 per1");
        acc(1, 20'h00700, 5, PER(6), 5, "R7 per6 R10");
        acc(1, 20'h00780, 0, NONE, 1, "R7 past per6");
        acc(1, 20'h003FF, 0, NONE, 1, "R7 below base");
        acc(1, 20'hF0400, 0, PER(0), 3, "R7 io high bits");
        acc(0, 20'h00400, 0, LO, 2, "R7 mem not per");
        acc(0, 20'h20000, 0, NONE, 1, "R3 mid needs base");

        // R6: mid 16K at 0x20000
        wr(3'd2, 16'h2000);
        acc(0, 20'h20000, 0, MID(0), 1, "R6 mid0");
        acc(0, 20'h21000, 0, MID(1), 1, "R6 mid1");
        acc(0, 20'h23FFF, 0, MID(3), 1, "R6 mid3");
        acc(0, 20'h24000, 0, NONE, 1, "R6 above mid");
        acc(0, 20'h1FFFF, 0, NONE, 1, "R6 below mid");

        // R4: upper 16K, 0 waits, ready honoured
        wr(3'd0, 16'h3C00);
        acc(0, 20'hFC000, 3, UP, 3, "R4 upper 16K R10");
        acc(0, 20'hFBFFF, 0, NONE, 1, "R4 below upper");

        // R12: restart during access ignored
        acc(0, 20'hFC000, 3, UP, 3, "R12 restart", 1);

        // R8: lower 256K overlaps mid
        wr(3'd1, 16'h3FC4);
        acc(0, 20'h20000, 0, LO, 1, "R8 lower over mid");
        // R6: size code 7 clamps to 512K
        wr(3'd3, 16'h7004);
        acc(0, 20'h80000, 0, MID(3), 1, "R6 clamp mid3");
        acc(0, 20'h40000, 0, MID(1), 1, "R6 clamp mid1");
        acc(0, 20'hA0000, 0, NONE, 1, "R6 clamp above");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "scoreboard drained", q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule